// File: doc/BRIEF.md
# Configurable-Row Orthogonal Latin Square Majority Decoder

This block corrects a 16-bit data word that was protected by a two-error-correcting orthogonal Latin square code with four symbols per side. The stored check bits arrive packed. Only the parity rows that a per-chip row-enable mask keeps are stored, and they are stored back to back. The decoder takes the data word, the packed check bits and the same row-enable mask that the encoder used. It first places each stored check bit back at its full row position.

For every data bit, each of the four parity rows that cover it gives one estimate of that bit. The estimate is the row's check bit XOR the other data bits in the row. A row that the mask turns off gives no estimate. The estimates that remain are voted together with the received bit. The voter's threshold follows how many rows are still enabled for that bit, so the correction happens in a single step.

The corrected word and a flag appear one clock after a valid input, together with an output valid. The flag says that at least one bit was changed.

Top module: `ols_adj_decoder`

## Requirements
- R1: While reset is active and after its release, `out_valid` is 0 until the first accepted input.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and the result of that input appears in the same cycle.
- R3: Enabled row j receives packed bit n, where n is the number of enabled rows with index below j. Packed bits at or above the number of enabled rows are ignored. Data bit 4r+c lies in row r (rows 0-3), row 4+c (rows 4-7), row 8+(r xor c) (rows 8-11) and row 12+(r xor 2c) (rows 12-15). Here 2c is a product in GF(4) with 2·1=2, 2·2=3 and 2·3=1.
- R4: With all 16 rows enabled, any one or two flipped bits among the data and check bits are corrected.
- R5: A disabled row gives no estimate. With only rows 0-7 enabled, any single flipped data bit is corrected.
- R6: With k rows enabled for a bit, the output is 1 when the number of ones among the k estimates and the received bit is above (k+1)/2, and 0 when it is below. With only rows 0-3 enabled (k=1), a disagreement between the estimate and the received bit is a tie, and the tie keeps the received value.
- R7: With three rows enabled per bit (rows 4-15), any single flipped data or check bit is corrected.
- R8: `out_corrected` is 1 exactly when `out_data` differs from the data word received one cycle earlier.
- R9: With an all-zero mask, the data passes through unchanged and `out_corrected` is 0.
- R10: While `in_valid` is low, `out_data` and `out_corrected` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_data | input | 16 | Received data word |
| in_chk | input | 16 | Packed stored check bits, lowest enabled row at bit 0 |
| in_mask | input | 16 | Parity row enables, bit j for row j |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 16 | Corrected data word |
| out_corrected | output | 1 | At least one data bit was changed |

## Verification
Several data words are encoded by the bench. Under full enable, each word is tried clean, with every single flip and with every pair of flips across data and check bits. This separates true two-error correction from a voter that handles only single errors or miscounts the received bit.

Rows 0-7 only and rows 4-15 only give partial masks with k=2 and k=3. Under these masks, garbage is placed above the used packed bits, which exposes any mistake in unpacking order or threshold.

Rows 0-3 only produce exact ties, which show whether ties keep the received value. The zero mask and idle cycles with changed inputs check pass-through and the clock enable.

// File: rtl/ols_dec_pkg.sv
package ols_dec_pkg;
  localparam int unsigned M     = 4;
  localparam int unsigned T     = 2;
  localparam int unsigned NGRP  = 2 * T;
  localparam int unsigned DW    = M * M;
  localparam int unsigned CW    = NGRP * M;
  localparam int unsigned IDXW  = $clog2(CW);
  localparam int unsigned CNTW  = $clog2(NGRP + 2) + 1;

  // doubling in GF(4) under x^2+x+1
  function automatic int unsigned gf_dbl(input int unsigned a);
    int unsigned s;
    s = (a << 1) & (M - 1);
    if ((a & 2) != 0) s = s ^ 3;
    return s;
  endfunction

  // row index of group g that covers data bit bi
  function automatic int unsigned grp_row(input int unsigned g, input int unsigned bi);
    int unsigned r, c, s;
    r = bi / M;
    c = bi % M;
    case (g)
      0:       s = r;
      1:       s = c;
      2:       s = r ^ c;
      default: s = r ^ gf_dbl(c);
    endcase
    return g * M + s;
  endfunction
endpackage

// File: rtl/ols_chk_expand.sv
module ols_chk_expand
  import ols_dec_pkg::*;
(
  input  logic [CW-1:0] chk_packed,
  input  logic [CW-1:0] row_en,
  output logic [CW-1:0] chk_full
);
  logic [IDXW-1:0] idx;

  always_comb begin
    idx      = '0;
    chk_full = '0;
    for (int r = 0; r < CW; r++) begin
      if (row_en[r]) begin
        chk_full[r] = chk_packed[idx];
        idx         = idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ols_row_parity.sv
module ols_row_parity
  import ols_dec_pkg::*;
(
  input  logic [DW-1:0] data,
  output logic [CW-1:0] row_par
);
  always_comb begin
    row_par = '0;
    for (int unsigned i = 0; i < DW; i++) begin
      for (int unsigned g = 0; g < NGRP; g++) begin
        row_par[grp_row(g, i)] = row_par[grp_row(g, i)] ^ data[i];
      end
    end
  end
endmodule

// File: rtl/ols_bit_voter.sv
module ols_bit_voter
  import ols_dec_pkg::*;
(
  input  logic            d_rx,
  input  logic [NGRP-1:0] est,
  input  logic [NGRP-1:0] en,
  output logic            d_fix
);
  logic [CNTW-1:0] ones;
  logic [CNTW-1:0] votes;

  always_comb begin
    ones  = CNTW'(d_rx);
    votes = CNTW'(1);
    for (int g = 0; g < NGRP; g++) begin
      ones  = ones + CNTW'(est[g] & en[g]);
      votes = votes + CNTW'(en[g]);
    end
    // compare 2*ones against votes; equality is a tie
    if ({ones, 1'b0} > {1'b0, votes})      d_fix = 1'b1;
    else if ({ones, 1'b0} < {1'b0, votes}) d_fix = 1'b0;
    else                                   d_fix = d_rx;
  end
endmodule

// File: rtl/ols_adj_decoder.sv
module ols_adj_decoder
  import ols_dec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_chk,
  input  logic [CW-1:0] in_mask,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_corrected
);
  logic [CW-1:0] chk_full;
  logic [CW-1:0] row_par;
  logic [DW-1:0] fix_next;
  logic          flag_next;
  logic [DW-1:0] data_q;
  logic          flag_q;
  logic          vld_q;

  ols_chk_expand u_expand (
    .chk_packed (in_chk),
    .row_en     (in_mask),
    .chk_full   (chk_full)
  );

  ols_row_parity u_par (
    .data    (in_data),
    .row_par (row_par)
  );

  for (genvar i = 0; i < DW; i++) begin : g_bit
    logic [NGRP-1:0] est;
    logic [NGRP-1:0] en;
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int unsigned ROW = grp_row(g, i);
      // row parity already contains the bit itself; cancel it
      assign est[g] = chk_full[ROW] ^ row_par[ROW] ^ in_data[i];
      assign en[g]  = in_mask[ROW];
    end
    ols_bit_voter u_vote (
      .d_rx  (in_data[i]),
      .est   (est),
      .en    (en),
      .d_fix (fix_next[i])
    );
  end

  assign flag_next = |(fix_next ^ in_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        data_q <= fix_next;
        flag_q <= flag_next;
      end
    end
  end

  assign out_valid     = vld_q;
  assign out_data      = data_q;
  assign out_corrected = flag_q;
endmodule

// File: rtl/ols_adj_decoder_chk.sv
module ols_adj_decoder_chk
  import ols_dec_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic [CW-1:0] in_mask,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_corrected
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_flag_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_corrected == (out_data != $past(in_data))));

  assert_zero_mask_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mask == '0) |=> (out_data == $past(in_data) && !out_corrected));

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_corrected)));
endmodule

bind ols_adj_decoder ols_adj_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_data       (in_data),
  .in_mask       (in_mask),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_corrected (out_corrected)
);

// File: tb/ols_adj_decoder_tb.sv
module ols_adj_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [15:0] in_chk;
  logic [15:0] in_mask;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_corrected;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ols_adj_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_chk(in_chk), .in_mask(in_mask), .out_valid(out_valid),
    .out_data(out_data), .out_corrected(out_corrected)
  );

  function automatic int row_of(int g, int b);
    int r = b / 4;
    int c = b % 4;
    int d;
    case (c) 0: d = 0; 1: d = 2; 2: d = 3; default: d = 1; endcase
    case (g) 0: return r; 1: return 4 + c; 2: return 8 + (r ^ c); default: return 12 + (r ^ d); endcase
  endfunction

  function automatic logic [15:0] encode(logic [15:0] d);
    logic [15:0] p = '0;
    for (int b = 0; b < 16; b++)
      for (int g = 0; g < 4; g++) p[row_of(g, b)] ^= d[b];
    return p;
  endfunction

  function automatic logic [15:0] pack(logic [15:0] full, logic [15:0] m, logic [15:0] junk);
    logic [15:0] o = junk;
    int n = 0;
    for (int r = 0; r < 16; r++)
      if (m[r]) begin o[n] = full[r]; n++; end
    return o;
  endfunction

  task automatic check(string req, logic [15:0] exp_d, logic exp_f);
    n_vec++;
    if (out_valid !== 1'b1 || out_data !== exp_d || out_corrected !== exp_f) begin
      n_bad++;
      $display("FAIL %s: valid=%b data=%h flag=%b expected valid=1 data=%h flag=%b",
               req, out_valid, out_data, out_corrected, exp_d, exp_f);
    end
  endtask

  // one valid input, sampled after its registered result appears
  task automatic run(logic [15:0] d, logic [15:0] c, logic [15:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_chk = c; in_mask = m;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // full-mask sweep: clean, all singles, all pairs over 32 bit positions (R4)
  task automatic sweep_full(logic [15:0] d);
    logic [31:0] cw;
    logic [31:0] e;
    cw = {encode(d), d};
    run(d, encode(d), 16'hFFFF);
    check("R4 clean", d, 1'b0);
    for (int a = 0; a < 32; a++) begin
      for (int b = a; b < 32; b++) begin
        e = cw;
        e[a] = ~e[a];
        if (b != a) e[b] = ~e[b];
        run(e[15:0], e[31:16], 16'hFFFF);
        check("R4", d, (e[15:0] != d));
      end
    end
  endtask

  logic [15:0] words [4];
  logic [15:0] d, full, c;

  initial begin
    words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'hA5C3; words[3] = 16'h1E77;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_chk = '0; in_mask = '0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R1: valid=%b expected 0", out_valid); end
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R1: valid=%b expected 0 after release", out_valid); end

    for (int w = 0; w < 4; w++) begin
      d = words[w];
      full = encode(d);
      sweep_full(d);

      // R5 / R3: rows 0-7, junk above packed bit 7
      c = pack(full, 16'h00FF, 16'h5A00 ^ {w[7:0], 8'h00});
      run(d, c, 16'h00FF);
      check("R3 partial clean", d, 1'b0);
      for (int b = 0; b < 16; b++) begin
        run(d ^ (16'h1 << b), c, 16'h00FF);
        check("R5 k=2 single", d, 1'b1);
      end

      // R7: rows 4-15, three rows per bit, junk in the four unused bits
      c = pack(full, 16'hFFF0, 16'hF000);
      run(d, c, 16'hFFF0);
      check("R3 rows4-15 clean", d, 1'b0);
      for (int b = 0; b < 16; b++) begin
        run(d ^ (16'h1 << b), c, 16'hFFF0);
        check("R7 data single", d, 1'b1);
      end
      for (int b = 0; b < 12; b++) begin
        run(d, c ^ (16'h1 << b), 16'hFFF0);
        check("R7 check single", d, 1'b0);
      end

      // R6: rows 0-3 only, ties keep received bit
      c = pack(full, 16'h000F, 16'hBEE0);
      for (int b = 0; b < 16; b++) begin
        run(d ^ (16'h1 << b), c, 16'h000F);
        check("R6 tie data", d ^ (16'h1 << b), 1'b0);
      end
      for (int b = 0; b < 4; b++) begin
        run(d, c ^ (16'h1 << b), 16'h000F);
        check("R6 tie check", d, 1'b0);
      end

      // R9: zero mask passes through even with garbage check bits
      run(d ^ 16'h0101, 16'hC3C3, 16'h0000);
      check("R9 pass", d ^ 16'h0101, 1'b0);

      // R10: idle cycle with changed inputs keeps result
      @(negedge clk);
      in_data = ~d; in_chk = ~full; in_mask = 16'hFFFF;
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0 || out_data !== (d ^ 16'h0101) || out_corrected !== 1'b0) begin
        n_bad++;
        $display("FAIL R10: valid=%b data=%h flag=%b expected valid=0 data=%h flag=0",
                 out_valid, out_data, out_corrected, d ^ 16'h0101);
      end
    end

    // R2: back-to-back inputs each appear one cycle later
    @(negedge clk);
    in_valid = 1'b1; in_data = words[2] ^ 16'h0004; in_chk = encode(words[2]); in_mask = 16'hFFFF;
    @(negedge clk);
    check("R2 first", words[2], 1'b1);
    in_data = words[3]; in_chk = encode(words[3]);
    @(negedge clk);
    check("R2 second", words[3], 1'b0);
    in_valid = 1'b0;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R2: valid=%b expected 0", out_valid); end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule